// File: doc/BRIEF.md
# Angle Hold Latch with Deferred Inhibit

This block sits between a tracking angle counter and a narrow host bus. The counter value changes one LSB at a time. Each change is marked by a busy strobe. Normally the block copies the counter into an internal holding register on every clock where no update is in progress. A host that wants a coherent reading pulls the active-low inhibit line. The register then freezes, and the host can fetch the upper and lower halves through two active-low byte enables without any risk of a carry between the two reads. The counter itself keeps tracking the whole time.

The host may assert inhibit at any moment without watching the busy line. If an update window is open when inhibit arrives, the freeze is held back as a pending request until the window closes. The register then takes one final copy of the settled value and holds it. An update window always lasts a fixed number of clocks, counted from the rising edge of the busy strobe. Successive rising edges must respect a minimum spacing. The bus is modelled as an 8-bit data vector plus a drive flag that stands in for the tri-state buffer. A byte-select flag shows which half is on the bus. The full held word is also available in parallel for a host that reads 16 bits at once.

Top module: `angle_hold_latch`

## Requirements
- R1: While inhibit is low and the freeze has taken effect, `holdWord` does not change, whatever `trackAngle` does.
- R2: When inhibit returns high, the first clock edge that lies outside an update window reloads `holdWord` with the current `trackAngle`.
- R3: If inhibit goes low while an update window is open, no copy is taken during the window. At the first edge after the window closes, `holdWord` captures `trackAngle` and then stays frozen.
- R4: `holdWord` never changes on a clock edge that falls inside an update window.
- R5: With `upperEnN` low, `busDrive` is 1, `byteSel` is 1 and `busData` equals `holdWord[15:8]`.
- R6: With `lowerEnN` low and `upperEnN` high, `busDrive` is 1, `byteSel` is 0 and `busData` equals `holdWord[7:0]`.
- R7: With both enables low, the upper byte wins the bus (`byteSel` is 1, `busData` is `holdWord[15:8]`).
- R8: With both enables high, the bus is released: `busDrive` is 0, `byteSel` is 0 and `busData` is 0.
- R9: With inhibit high and no update window open, `holdWord` equals the `trackAngle` value sampled at the previous edge. With both enables low this makes the block transparent.
- R10: An update window opens at the edge where `busyStrobe` is first seen high and spans `BUSY_CYCLES` edges, even if the strobe is shorter than that.
- R11: Rising edges of `busyStrobe` are at least `BUSY_CYCLES + MIN_GAP` clocks apart. In the gap after a window, with inhibit high, `holdWord` reloads on every edge.
- R12: Reset (active-low, asynchronous) clears `holdWord` to 0 and clears any pending freeze. The bus drive depends only on the enables, so it is released while they are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trackAngle | input | 16 | Live value of the tracking counter |
| busyStrobe | input | 1 | High while the counter is making a one-LSB update |
| inhibitN | input | 1 | Active-low request to freeze the held word |
| upperEnN | input | 1 | Active-low enable for bits 15:8 onto the bus |
| lowerEnN | input | 1 | Active-low enable for bits 7:0 onto the bus |
| busData | output | 8 | Byte presented on the shared bus, 0 when released |
| busDrive | output | 1 | Model of the tri-state enable; 1 when the bus is driven |
| byteSel | output | 1 | 1 when the upper byte is on the bus |
| holdWord | output | 16 | Full held word, for 16-bit parallel reads |

## Verification
The hardest situation to reach is inhibit falling in the middle of an update window while `trackAngle` is still moving. The stimulus has to raise the strobe, change the angle during the window, and drop inhibit a couple of edges later. It must then show that the copy lands exactly at the first edge after the window, and on no edge before it. The vector table arranges this twice: once from the tracking state, and once with inhibit released inside a window that opened while the word was frozen. A directed case then uses a single-cycle strobe. That case confirms that the window length comes from `BUSY_CYCLES` and not from the strobe width.

// File: rtl/angle_latch_pkg.sv
package angle_latch_pkg;

  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_WAIT  = 2'd1,
    ST_HOLD  = 2'd2
  } latchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;   // copy trackAngle into the holding register
    logic busyWin;    // an update window is open at this edge
    logic pending;    // freeze requested, waiting for the window to close
    logic frozen;     // holding register is frozen
    logic driveBus;   // some byte is on the bus
    logic selUpper;   // the upper byte is on the bus
  } latchCtl_t;

endpackage

// File: rtl/angle_latch_ctrl.sv
module angle_latch_ctrl
  import angle_latch_pkg::*;
#(
  parameter int BUSY_CYCLES = 47
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busyStrobe,
  input  logic      inhibitN,
  input  logic      upperEnN,
  input  logic      lowerEnN,
  output latchCtl_t ctl
);

  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic             strobePrev;
  logic [CNT_W-1:0] winCnt;
  logic             strobeRise;
  logic             busyWin;
  latchState_e      state, stateNext;
  logic             loadWord;

  assign strobeRise = busyStrobe && !strobePrev;
  assign busyWin    = strobeRise || (winCnt != '0);

  // update window: BUSY_CYCLES edges starting at the strobe's rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      winCnt     <= '0;
    end else begin
      strobePrev <= busyStrobe;
      if (strobeRise) begin
        winCnt <= WIN_LOAD;
      end else if (winCnt != '0) begin
        winCnt <= winCnt - 1'b1;
      end
    end
  end

  always_comb begin
    stateNext = state;
    loadWord  = 1'b0;
    unique case (state)
      ST_TRACK: begin
        if (inhibitN) begin
          loadWord = !busyWin;
        end else if (busyWin) begin
          stateNext = ST_WAIT;
        end else begin
          loadWord  = 1'b1;
          stateNext = ST_HOLD;
        end
      end
      ST_WAIT: begin
        if (inhibitN) begin
          loadWord  = !busyWin;
          stateNext = ST_TRACK;
        end else if (!busyWin) begin
          loadWord  = 1'b1;
          stateNext = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (inhibitN) begin
          loadWord  = !busyWin;
          stateNext = ST_TRACK;
        end
      end
      default: begin
        stateNext = ST_TRACK;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_TRACK;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    ctl.loadWord = loadWord;
    ctl.busyWin  = busyWin;
    ctl.pending  = (state == ST_WAIT);
    ctl.frozen   = (state == ST_HOLD);
    ctl.driveBus = !upperEnN || !lowerEnN;
    ctl.selUpper = !upperEnN;
  end

endmodule

// File: rtl/angle_latch_path.sv
module angle_latch_path
  import angle_latch_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] trackAngle,
  input  latchCtl_t         ctl,
  output logic [WORD_W/2-1:0] busData,
  output logic              busDrive,
  output logic              byteSel,
  output logic [WORD_W-1:0] holdWord
);

  localparam int BUS_W  = WORD_W / 2;
  localparam int LANES  = 2;

  logic [WORD_W-1:0] wordReg;
  logic [BUS_W-1:0]  lane [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (ctl.loadWord) begin
      wordReg <= trackAngle;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = wordReg[g*BUS_W +: BUS_W];
  end

  always_comb begin
    busDrive = ctl.driveBus;
    byteSel  = ctl.driveBus && ctl.selUpper;
    if (!ctl.driveBus) begin
      busData = '0;
    end else if (ctl.selUpper) begin
      busData = lane[1];
    end else begin
      busData = lane[0];
    end
  end

  assign holdWord = wordReg;

endmodule

// File: rtl/angle_hold_latch.sv
module angle_hold_latch
  import angle_latch_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int BUSY_CYCLES = 47,
  parameter int MIN_GAP     = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] trackAngle,
  input  logic              busyStrobe,
  input  logic              inhibitN,
  input  logic              upperEnN,
  input  logic              lowerEnN,
  output logic [WORD_W/2-1:0] busData,
  output logic              busDrive,
  output logic              byteSel,
  output logic [WORD_W-1:0] holdWord
);

  latchCtl_t ctl;
  logic      busyWin;
  logic      pendingFreeze;

  angle_latch_ctrl #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busyStrobe(busyStrobe),
    .inhibitN  (inhibitN),
    .upperEnN  (upperEnN),
    .lowerEnN  (lowerEnN),
    .ctl       (ctl)
  );

  angle_latch_path #(
    .WORD_W(WORD_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .trackAngle(trackAngle),
    .ctl       (ctl),
    .busData   (busData),
    .busDrive  (busDrive),
    .byteSel   (byteSel),
    .holdWord  (holdWord)
  );

  assign busyWin       = ctl.busyWin;
  assign pendingFreeze = ctl.pending;

endmodule

// File: rtl/angle_hold_latch_chk.sv
module angle_hold_latch_chk #(
  parameter int WORD_W      = 16,
  parameter int BUSY_CYCLES = 47,
  parameter int MIN_GAP     = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] trackAngle,
  input logic              busyStrobe,
  input logic              inhibitN,
  input logic              upperEnN,
  input logic              lowerEnN,
  input logic [WORD_W/2-1:0] busData,
  input logic              busDrive,
  input logic              byteSel,
  input logic [WORD_W-1:0] holdWord,
  input logic              busyWin,
  input logic              pendingFreeze
);

  localparam int SPACING = BUSY_CYCLES + MIN_GAP;
  localparam int SP_W    = $clog2(SPACING + 1);
  localparam int BUS_W   = WORD_W / 2;

  logic            chkPrev;
  logic            chkSeen;
  logic [SP_W-1:0] sinceRise;
  logic            chkRise;

  assign chkRise = busyStrobe && !chkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkPrev   <= 1'b0;
      chkSeen   <= 1'b0;
      sinceRise <= SP_W'(SPACING);
    end else begin
      chkPrev <= busyStrobe;
      if (chkRise) begin
        chkSeen   <= 1'b1;
        sinceRise <= SP_W'(1);
      end else if (sinceRise < SP_W'(SPACING)) begin
        sinceRise <= sinceRise + 1'b1;
      end
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!inhibitN && !busyWin) ##1 !inhibitN |=> $stable(holdWord));

  assert_deferred_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pendingFreeze && !busyWin && !inhibitN) |=> holdWord == $past(trackAngle));

  assert_busy_noload_R4: assert property (@(posedge clk) disable iff (!rstN)
    busyWin |=> $stable(holdWord));

  assert_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    !upperEnN |-> (busDrive && byteSel && busData == holdWord[WORD_W-1:BUS_W]));

  assert_lower_R6: assert property (@(posedge clk) disable iff (!rstN)
    (upperEnN && !lowerEnN) |-> (busDrive && !byteSel && busData == holdWord[BUS_W-1:0]));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (upperEnN && lowerEnN) |-> (!busDrive && !byteSel && busData == '0));

  assert_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inhibitN && !busyWin) |=> holdWord == $past(trackAngle));

  assert_window_open_R10: assert property (@(posedge clk) disable iff (!rstN)
    chkRise |-> busyWin);

  assert_strobe_spacing_R11: assert property (@(posedge clk) disable iff (!rstN)
    (chkRise && chkSeen) |-> sinceRise >= SP_W'(SPACING));

  assert_reset_R12: assert property (@(posedge clk)
    !rstN |=> (holdWord == '0 && !pendingFreeze));

endmodule

bind angle_hold_latch angle_hold_latch_chk #(
  .WORD_W     (WORD_W),
  .BUSY_CYCLES(BUSY_CYCLES),
  .MIN_GAP    (MIN_GAP)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .trackAngle   (trackAngle),
  .busyStrobe   (busyStrobe),
  .inhibitN     (inhibitN),
  .upperEnN     (upperEnN),
  .lowerEnN     (lowerEnN),
  .busData      (busData),
  .busDrive     (busDrive),
  .byteSel      (byteSel),
  .holdWord     (holdWord),
  .busyWin      (busyWin),
  .pendingFreeze(pendingFreeze)
);

// File: tb/sim_angle_hold_latch.sv
module sim_angle_hold_latch;

  localparam int BUSY = 5;
  localparam int GAP  = 3;
  localparam int NVEC = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] trackAngle = '0;
  logic        busyStrobe = 1'b0;
  logic        inhibitN = 1'b1;
  logic        upperEnN = 1'b1;
  logic        lowerEnN = 1'b1;
  logic [7:0]  busData;
  logic        busDrive;
  logic        byteSel;
  logic [15:0] holdWord;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  // reference state
  logic        mPrev = 1'b0;
  int          mCnt = 0;
  int          mState = 0; // 0 track, 1 waiting, 2 frozen
  logic [15:0] mWord = '0;

  always #4 clk = ~clk;

  angle_hold_latch #(
    .WORD_W(16), .BUSY_CYCLES(BUSY), .MIN_GAP(GAP)
  ) u0 (
    .clk(clk), .rstN(rstN), .trackAngle(trackAngle), .busyStrobe(busyStrobe),
    .inhibitN(inhibitN), .upperEnN(upperEnN), .lowerEnN(lowerEnN),
    .busData(busData), .busDrive(busDrive), .byteSel(byteSel), .holdWord(holdWord)
  );

  // {inhibitN, upperEnN, lowerEnN, busyStrobe, trackAngle}; strobe rises >= 8 apart
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b1000, 16'h0100}, {4'b1100, 16'h0101}, {4'b1010, 16'h0102}, {4'b1110, 16'h0203},
    {4'b1101, 16'h0204}, {4'b1101, 16'h0205}, {4'b1010, 16'h0206}, {4'b0100, 16'h0207},
    {4'b0010, 16'h0208}, {4'b0100, 16'h0209}, {4'b0010, 16'h020A}, {4'b0100, 16'h020B},
    {4'b0001, 16'h030C}, {4'b1100, 16'h030D}, {4'b1010, 16'h030E}, {4'b1100, 16'h030F},
    {4'b1000, 16'h0310}, {4'b1100, 16'h0311}, {4'b1010, 16'h0312}, {4'b0110, 16'h0413},
    {4'b0010, 16'h0414}, {4'b0101, 16'h0415}, {4'b1100, 16'h0416}, {4'b1000, 16'h0417}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkBus(input logic enU, input logic enL);
    if (!enU) begin
      check(enL ? "R5 upper" : "R7 priority", {busDrive, byteSel, busData}, {2'b11, mWord[15:8]});
    end else if (!enL) begin
      check("R6 lower", {busDrive, byteSel, busData}, {2'b10, mWord[7:0]});
    end else begin
      check("R8 release", {busDrive, byteSel, busData}, 10'd0);
    end
  endtask

  // drive one cycle, advance the reference, check after the edge
  task automatic step(input logic inh, input logic enU, input logic enL,
                      input logic strb, input logic [15:0] trk);
    logic rise, win, load;
    string tag;
    @(negedge clk);
    inhibitN = inh; upperEnN = enU; lowerEnN = enL; busyStrobe = strb; trackAngle = trk;
    rise = strb && !mPrev;
    win  = rise || (mCnt != 0);
    load = 1'b0;
    tag  = "R9 follow";
    if (win) tag = "R4 busy";
    else if (!inh && mState == 1) tag = "R3 deferred";
    else if (!inh && mState == 2) tag = "R1 hold";
    else if (inh && mState != 0) tag = "R2 resume";
    case (mState)
      0: if (inh) load = !win; else if (win) mState = 1; else begin load = 1'b1; mState = 2; end
      default: if (inh) begin load = !win; mState = 0; end
               else if (mState == 1 && !win) begin load = 1'b1; mState = 2; end
    endcase
    if (load) mWord = trk;
    mCnt  = rise ? BUSY - 1 : (mCnt != 0 ? mCnt - 1 : 0);
    mPrev = strb;
    @(posedge clk);
    #2;
    check(tag, {16'd0, holdWord}, {16'd0, mWord});
    checkBus(enU, enL);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; inhibitN = 1'b0; upperEnN = 1'b1; lowerEnN = 1'b1; busyStrobe = 1'b0;
    mPrev = 1'b0; mCnt = 0; mState = 0; mWord = '0;
    #1;
    check("R12 reset word", {16'd0, holdWord}, 32'd0);
    check("R12 reset bus", {22'd0, busDrive, byteSel, busData}, 32'd0);
    @(negedge clk);
    rstN = 1'b1; inhibitN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R12 reset word", {16'd0, holdWord}, 32'd0);
    check("R8 release at reset", {22'd0, busDrive, byteSel, busData}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0]);
    end
    repeat (8) step(1'b1, 1'b1, 1'b1, 1'b0, trackAngle);

    // R2 / R1: freeze with no busy, move the angle, release
    step(1'b0, 1'b1, 1'b1, 1'b0, 16'hA000);
    for (int k = 1; k <= 4; k++) step(1'b0, 1'b0, 1'b1, 1'b0, 16'hA000 + 16'(k));
    check("R1 frozen value", {16'd0, holdWord}, 32'h0000A000);
    step(1'b1, 1'b1, 1'b1, 1'b0, 16'hA055);
    check("R2 reload after release", {16'd0, holdWord}, 32'h0000A055);

    // R10: one-cycle strobe still blocks BUSY edges
    step(1'b1, 1'b1, 1'b1, 1'b1, 16'hB000);
    check("R10 no load at window start", {16'd0, holdWord}, 32'h0000A055);
    for (int k = 1; k < BUSY; k++) begin
      step(1'b1, 1'b1, 1'b1, 1'b0, 16'hB000 + 16'(k));
      check("R10 no load in window", {16'd0, holdWord}, 32'h0000A055);
    end
    // R11: gap edges reload every cycle
    for (int k = 0; k < GAP; k++) begin
      step(1'b1, 1'b1, 1'b1, 1'b0, 16'hC000 + 16'(k));
      check("R11 gap reload", {16'd0, holdWord}, 32'h0000C000 + k);
    end

    // R3: inhibit drops inside a window while the angle moves
    step(1'b1, 1'b1, 1'b1, 1'b1, 16'hD000);
    step(1'b1, 1'b1, 1'b1, 1'b1, 16'hD001);
    step(1'b0, 1'b1, 1'b1, 1'b0, 16'hD002);
    step(1'b0, 1'b1, 1'b1, 1'b0, 16'hD003);
    step(1'b0, 1'b1, 1'b1, 1'b0, 16'hD004);
    check("R3 nothing captured in window", {16'd0, holdWord}, 32'h0000C002);
    step(1'b0, 1'b1, 1'b1, 1'b0, 16'hD005);
    check("R3 capture after window", {16'd0, holdWord}, 32'h0000D005);
    step(1'b0, 1'b0, 1'b0, 1'b0, 16'hD006);
    check("R3 stays frozen", {16'd0, holdWord}, 32'h0000D005);
    check("R7 priority upper", {22'd0, busDrive, byteSel, busData}, {22'd0, 2'b11, 8'hD0});

    // R12: reset mid-run, then transparent follow (R9)
    applyReset();
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h1357);
    check("R9 transparent", {16'd0, holdWord}, 32'h00001357);
    step(1'b1, 1'b1, 1'b0, 1'b0, 16'h1358);
    check("R6 lower byte", {24'd0, busData}, 32'h00000058);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule